// File: doc/BRIEF.md
# Self-Test Context Register with Board-Reset Sequencer

This block is a single 8-bit control/status location that built-in-test software reaches over a simple byte register bus at offset 0x629. Most of its bits are plain storage. Software uses them to record how far self-test has progressed: the run status, the pass/fail result, the two mode enables and a "has run" flag. These bits are kept through ordinary resets, so the test context is still there after a warm restart. Only a power-failure reset wipes them.

The top bit is a self-clearing trigger. Writing 1 to it starts a board reset, which an internal sequencer holds for a fixed number of clock cycles. Bit 1 chooses whether the same window also drives the system reset output. The sequencer gives a one-cycle completion pulse when the window ends. At that point the trigger and the system-reset enable both return to 0.

Top module: `selftest_ctx_reg`

## Requirements
- R1: After a power-fail reset, the register reads 0x10, and `board_rst_o`, `sys_rst_o` and `rst_done_o` are all 0.
- R2: A read (`bus_sel`=1, `bus_wr`=0, `bus_addr`=0x629) returns the stored bits 6:0, with bit 7 showing whether a board reset is in progress. A read at any other address returns 0. A write at any other address changes nothing.
- R3: A general reset (`rst_n` low) keeps bits 6:5, 4, 3, 2 and 0. It clears bit 1, bit 7 and all reset outputs.
- R4: A power-fail reset (`pf_rst_n` low) loads every bit with its default: bit 4 = 1 and all other bits = 0.
- R5: A write with bit 7 = 1 while no reset is in progress raises `board_rst_o` from the next cycle for exactly PULSE_LEN cycles (16 by default). Bit 7 reads 1 during that window.
- R6: `sys_rst_o` is high for the same window as `board_rst_o` exactly when bit 1 of the write carrying the request is 1. Otherwise it stays low.
- R7: A write with bit 7 = 0 never raises any reset output, whatever bit 1 holds.
- R8: A write of 1 to bit 7 while a window is running neither extends nor restarts it. The other bits of that write are still stored.
- R9: In the cycle after the window ends, `rst_done_o` is high for one cycle, and bits 7 and 1 read 0. The other bits are unchanged.
- R10: A write that sets bit 1 in the last cycle of a window is overridden by the completion: bit 1 reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | General synchronous reset, active low; context bits survive it |
| pf_rst_n | input | 1 | Power-fail synchronous reset, active low; loads all defaults |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not selected |
| board_rst_o | output | 1 | Board reset, active high |
| sys_rst_o | output | 1 | System reset, active high |
| rst_done_o | output | 1 | One-cycle pulse after a reset window ends |

## Verification
Two events can fall in the same clock edge: the sequencer finishing its window, and a software write to the same register. The bench provokes this by counting cycles from the request and placing a write that sets bit 1 exactly on the completion edge. It also places a second request inside a running window. It then judges the result through read-back and through the cycle counts of the reset outputs: bit 1 must read 0, only one completion pulse may appear, and the window must last exactly PULSE_LEN cycles.

// File: rtl/selftest_ctx_pkg.sv
package selftest_ctx_pkg;
   localparam int DATA_W   = 8;
   localparam int BIT_REQ  = 7;
   localparam int BIT_SYS  = 1;
   // bits kept across general reset: 6..2 and 0
   localparam logic [6:0] STICKY_MASK = 7'b111_1101;
   // defaults of bits 6..0: only the fail flag (bit 4) is set
   localparam logic [6:0] CTX_DEFAULT = 7'b001_0000;

   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_HOLD = 1'b1} seq_state_t;

   function automatic logic [DATA_W-1:0] pack_reg(input logic busy, input logic [6:0] ctx);
      return {busy, ctx};
   endfunction
endpackage

// File: rtl/stc_bus_decode.sv
module stc_bus_decode #(
   parameter int          ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] REG_ADDR = 12'h629
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              wdata_req,
   output logic              wr_hit,
   output logic              rd_hit,
   output logic              req_hit
);
   logic addr_match;
   assign addr_match = (bus_addr == REG_ADDR);
   assign wr_hit     = bus_sel &  bus_wr & addr_match;
   assign rd_hit     = bus_sel & ~bus_wr & addr_match;
   assign req_hit    = wr_hit & wdata_req;
endmodule

// File: rtl/stc_ctx_store.sv
module stc_ctx_store
   import selftest_ctx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pf_rst_n,
   input  logic       wr_en,
   input  logic       clr_ctl,
   input  logic [6:0] wdata,
   output logic [6:0] ctx_q
);
   for (genvar b = 0; b < 7; b++) begin : g_bit
      if (STICKY_MASK[b]) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!pf_rst_n)  ctx_q[b] <= CTX_DEFAULT[b];
            else if (wr_en) ctx_q[b] <= wdata[b];
         end
      end else begin : g_volatile
         always_ff @(posedge clk) begin
            if (!pf_rst_n || !rst_n) ctx_q[b] <= CTX_DEFAULT[b];
            else if (clr_ctl)        ctx_q[b] <= 1'b0;
            else if (wr_en)          ctx_q[b] <= wdata[b];
         end
      end
   end
endmodule

// File: rtl/stc_rst_seq.sv
module stc_rst_seq
   import selftest_ctx_pkg::*;
#(
   parameter int PULSE_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pf_rst_n,
   input  logic req,
   input  logic sys_sel,
   output logic busy_o,
   output logic sys_o,
   output logic done_o,
   output logic finish_o
);
   seq_state_t state_q;
   logic       sys_en_q;
   logic       last;
   logic       accept;

   assign accept   = req & (state_q == SEQ_IDLE);
   assign finish_o = (state_q == SEQ_HOLD) & last;

   if (PULSE_LEN > 1) begin : g_count
      localparam int CNT_W = $clog2(PULSE_LEN);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN - 1);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!pf_rst_n || !rst_n)   cnt_q <= '0;
         else if (accept)           cnt_q <= CNT_LOAD;
         else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
      end
      assign last = (cnt_q == '0);
   end else begin : g_single
      assign last = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!pf_rst_n || !rst_n) begin
         state_q  <= SEQ_IDLE;
         sys_en_q <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= finish_o;
         if (accept) begin
            state_q  <= SEQ_HOLD;
            sys_en_q <= sys_sel;
         end else if (finish_o) begin
            state_q  <= SEQ_IDLE;
            sys_en_q <= 1'b0;
         end
      end
   end

   assign busy_o = (state_q == SEQ_HOLD);
   assign sys_o  = busy_o & sys_en_q;
endmodule

// File: rtl/selftest_ctx_reg.sv
module selftest_ctx_reg
   import selftest_ctx_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 12'h629,
   parameter int                PULSE_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pf_rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              board_rst_o,
   output logic              sys_rst_o,
   output logic              rst_done_o
);
   if (PULSE_LEN < 1) begin : g_bad_len
      $error("PULSE_LEN must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
      $error("ADDR_W out of range");
   end

   logic       wr_hit, rd_hit, req_hit;
   logic       busy, finish;
   logic [6:0] ctx_q;

   stc_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .wdata_req (bus_wdata[BIT_REQ]),
      .wr_hit    (wr_hit),
      .rd_hit    (rd_hit),
      .req_hit   (req_hit)
   );

   stc_rst_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pf_rst_n (pf_rst_n),
      .req      (req_hit),
      .sys_sel  (bus_wdata[BIT_SYS]),
      .busy_o   (busy),
      .sys_o    (sys_rst_o),
      .done_o   (rst_done_o),
      .finish_o (finish)
   );

   stc_ctx_store u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .pf_rst_n (pf_rst_n),
      .wr_en    (wr_hit),
      .clr_ctl  (finish),
      .wdata    (bus_wdata[6:0]),
      .ctx_q    (ctx_q)
   );

   assign board_rst_o = busy;
   assign bus_rdata   = rd_hit ? pack_reg(busy, ctx_q) : '0;
endmodule

// File: rtl/selftest_ctx_reg_chk.sv
module selftest_ctx_reg_chk #(
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 12'h629,
   parameter int                PULSE_LEN = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pf_rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              board_rst_o,
   input logic              sys_rst_o,
   input logic              rst_done_o
);
   localparam int HW = $clog2(PULSE_LEN + 2) + 1;
   logic [HW-1:0] hi_cnt;
   logic          any_rst;
   logic          req_now;
   logic          rd_now;

   assign any_rst = !rst_n || !pf_rst_n;
   assign req_now = bus_sel && bus_wr && (bus_addr == REG_ADDR) && bus_wdata[7];
   assign rd_now  = bus_sel && !bus_wr && (bus_addr == REG_ADDR);

   always_ff @(posedge clk) begin
      if (any_rst)          hi_cnt <= '0;
      else if (board_rst_o) hi_cnt <= hi_cnt + 1'b1;
      else                  hi_cnt <= '0;
   end

   AST_START_ON_REQ: assert property (@(posedge clk) disable iff (any_rst)
      (req_now && !board_rst_o) |=> board_rst_o); // R5
   AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (any_rst)
      $fell(board_rst_o) |-> (hi_cnt == HW'(PULSE_LEN))); // R8
   AST_SYS_INSIDE: assert property (@(posedge clk) disable iff (any_rst)
      sys_rst_o |-> board_rst_o); // R6
   AST_SYS_STEADY: assert property (@(posedge clk) disable iff (any_rst)
      (board_rst_o && $past(board_rst_o)) |-> $stable(sys_rst_o)); // R6
   AST_NO_SPONT_RST: assert property (@(posedge clk) disable iff (any_rst)
      (!board_rst_o && !req_now) |=> !board_rst_o); // R7
   AST_DONE_AFTER: assert property (@(posedge clk) disable iff (any_rst)
      $fell(board_rst_o) |-> rst_done_o); // R9
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (any_rst)
      (rst_done_o && rd_now) |-> (bus_rdata[7] == 1'b0 && bus_rdata[1] == 1'b0)); // R10
endmodule

bind selftest_ctx_reg selftest_ctx_reg_chk #(
   .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .PULSE_LEN(PULSE_LEN)
) chk_i (
   .clk(clk), .rst_n(rst_n), .pf_rst_n(pf_rst_n), .bus_sel(bus_sel),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .board_rst_o(board_rst_o),
   .sys_rst_o(sys_rst_o), .rst_done_o(rst_done_o)
);

// File: tb/selftest_ctx_reg_tb_top.sv
`timescale 1ns/1ps
module selftest_ctx_reg_tb_top;
   localparam int          ADDR_W = 12;
   localparam logic [11:0] RADDR  = 12'h629;
   localparam int          PLEN   = 16;
   localparam int          NVEC   = 6;
   // {write data, expected read-back}
   localparam logic [15:0] VEC [NVEC] = '{
      16'h00_00, 16'h7F_7F, 16'h55_55, 16'h2A_2A, 16'h61_61, 16'h1E_1E };

   logic clk = 0, rst_n = 1, pf_rst_n = 1;
   logic bus_sel = 0, bus_wr = 0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic board_rst_o, sys_rst_o, rst_done_o;
   int n_tests = 0, n_fail = 0;
   int hi_cnt = 0, sys_cnt = 0, done_cnt = 0;

   always #5 clk = ~clk;

   selftest_ctx_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RADDR), .PULSE_LEN(PLEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .pf_rst_n(pf_rst_n), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .board_rst_o(board_rst_o),
      .sys_rst_o(sys_rst_o), .rst_done_o(rst_done_o));

   always @(negedge clk) begin
      if (board_rst_o) hi_cnt++;
      if (sys_rst_o)   sys_cnt++;
      if (rst_done_o)  done_cnt++;
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic clr_cnt();
      hi_cnt = 0; sys_cnt = 0; done_cnt = 0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string req);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 check(req, bus_rdata, exp);
      #1 bus_sel = 0;
   endtask

   task automatic pulse_pf();
      pf_rst_n = 0; @(posedge clk); @(posedge clk); @(negedge clk); pf_rst_n = 1;
   endtask

   task automatic pulse_gen();
      rst_n = 0; @(posedge clk); @(posedge clk); @(negedge clk); rst_n = 1;
   endtask

   initial begin
      #(200000 * 10);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      pulse_pf();
      rst_n = 1;
      // R1 reset state
      rd(RADDR, 8'h10, "R1");
      check("R1 board", board_rst_o, 0);
      check("R1 sys", sys_rst_o, 0);
      check("R1 done", rst_done_o, 0);

      // R2 / R7 table walk: plain storage writes, no resets
      clr_cnt();
      for (int i = 0; i < NVEC; i++) begin
         wr(RADDR, VEC[i][15:8]);
         @(negedge clk);
         rd(RADDR, VEC[i][7:0], "R2");
      end
      check("R7 no board reset", hi_cnt, 0);
      check("R7 no sys reset", sys_cnt, 0);

      // R2 other address
      wr(RADDR, 8'h00);
      wr(RADDR + 12'd1, 8'hFF);
      @(negedge clk);
      rd(RADDR, 8'h00, "R2 foreign write");
      rd(RADDR + 12'd1, 8'h00, "R2 foreign read");
      check("R2 foreign no reset", board_rst_o, 0);

      // R7 bit1 alone
      clr_cnt();
      wr(RADDR, 8'h02);
      repeat (4) @(negedge clk);
      check("R7 bit1 alone", hi_cnt + sys_cnt, 0);

      // R3 general reset keeps sticky
      wr(RADDR, 8'h6F);
      pulse_gen();
      rd(RADDR, 8'h6D, "R3");

      // R4 power-fail reset
      pulse_pf();
      rd(RADDR, 8'h10, "R4");

      // R5 R6 R9 request with system reset
      clr_cnt();
      wr(RADDR, 8'h8B);
      rd(RADDR, 8'h8B, "R5 busy read");
      repeat (PLEN - 1) @(negedge clk);
      check("R5 still high last", board_rst_o, 1);
      check("R9 no done yet", done_cnt, 0);
      @(negedge clk);
      check("R5 low after window", board_rst_o, 0);
      check("R9 done pulse", rst_done_o, 1);
      rd(RADDR, 8'h09, "R9 clears 7 and 1");
      check("R5 window length", hi_cnt, PLEN);
      check("R6 sys length", sys_cnt, PLEN);
      @(negedge clk);
      check("R9 single pulse", rst_done_o, 0);

      // R6 request without system reset
      clr_cnt();
      wr(RADDR, 8'h90);
      repeat (PLEN + 4) @(negedge clk);
      check("R6 no sys", sys_cnt, 0);
      check("R6 board len", hi_cnt, PLEN);
      rd(RADDR, 8'h10, "R9 after no-sys");

      // R8 zero to bit 7, and re-request during window
      clr_cnt();
      wr(RADDR, 8'h00);
      @(negedge clk);
      check("R8 zero write", hi_cnt, 0);
      wr(RADDR, 8'h80);
      repeat (4) @(negedge clk);
      wr(RADDR, 8'h84);
      repeat (PLEN + 4) @(negedge clk);
      check("R8 window not extended", hi_cnt, PLEN);
      check("R8 one done", done_cnt, 1);
      rd(RADDR, 8'h04, "R8 other bits stored");

      // R10 write on completion edge
      clr_cnt();
      wr(RADDR, 8'h80);
      repeat (PLEN - 1) @(negedge clk);
      wr(RADDR, 8'h02);
      rd(RADDR, 8'h00, "R10 bit1 overridden");
      repeat (PLEN + 4) @(negedge clk);
      check("R10 window", hi_cnt, PLEN);
      check("R10 sys", sys_cnt, 0);
      check("R10 one done", done_cnt, 1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule